// File: doc/BRIEF.md
# Bidding Interrupt Arbiter with Context Capture

This block decides which of eighteen interrupt sources of a two-channel serial device is put in front of the host processor. Each source has an 8-bit bid that software can rewrite at any time. Every cycle the arbiter finds the highest bid among the sources that are active and not masked. It pulls an active-low request line whenever that winning bid is strictly greater than a programmable threshold.

When the host acknowledges the interrupt, or issues an update command, the block freezes the latest arbitration result into a context register. The context holds the source index, the channel, a 3-bit source type and, for receive and transmit sources, the FIFO fill level. The frozen context drives two things. The first is the interrupt vector, which is either a fixed programmed byte or that byte with the type and/or channel codes substituted in. The second is the select of a global data path that serves the channel named in the context.

Top module: `bid_irq_arbiter`

## Requirements
- R1: After reset the request output is high (inactive), the context (valid, channel, type, source, fill) is all zero, every bid, the threshold, the vector byte and the control bits are zero, so the vector output reads 0x00.
- R2: Among sources whose active input is high and mask input low, the one with the largest bid wins, and its index, channel and type appear in the context on the next capture.
- R3: When two eligible sources share the largest bid, the one with the lower index wins.
- R4: A source with bid 0, or with its mask bit set, never wins and never causes a request.
- R5: The request output is low exactly when the winning bid is strictly greater than the threshold register. A bid equal to the threshold gives no request. The output follows a change in sources or registers after one clock edge.
- R6: A capture happens on the clock edge at which the acknowledge input is first seen high (its rising edge), or on any edge with the update input high. Between captures the context does not change, even if the sources change or the acknowledge input stays high.
- R7: Sources 0 to 8 belong to channel 0 and sources 9 to 17 to channel 1. Within a channel, local position p (0 to 6) has type p, and local positions 7 and 8 both have type 7.
- R8: The captured fill level is the channel's receive fill for type 0, the channel's transmit fill for type 1, and 0 for every other type.
- R9: The vector output is the vector byte with bits [2:0] replaced by the context type when control bit 0 is set, and bit 3 replaced by the context channel when control bit 1 is set. Bits [7:4] always come from the vector byte.
- R10: The global data output passes the channel 1 input when the context channel is 1, and the channel 0 input otherwise.
- R11: Register writes use address 0 to 17 for the bid of that source, 18 for the threshold, 19 for the vector byte and 20 for the control bits [1:0]. Writes to addresses 21 to 31 change nothing.
- R12: A capture taken while there is no request sets context valid to 0 and all context fields to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| src_act | input | 18 | Source condition active, one bit per source |
| src_mask | input | 18 | Source masked when bit is 1 |
| rx_fill_a | input | 8 | Channel 0 receive FIFO fill level |
| rx_fill_b | input | 8 | Channel 1 receive FIFO fill level |
| tx_fill_a | input | 8 | Channel 0 transmit FIFO fill level |
| tx_fill_b | input | 8 | Channel 1 transmit FIFO fill level |
| iack | input | 1 | Interrupt acknowledge, captures on rising edge |
| upd_cmd | input | 1 | Update command, captures while high |
| irq_n | output | 1 | Active-low interrupt request |
| vector | output | 8 | Interrupt vector |
| ctx_valid | output | 1 | Context holds a real interrupt |
| ctx_chan | output | 1 | Context channel |
| ctx_type | output | 3 | Context source type |
| ctx_src | output | 5 | Context source index |
| ctx_fill | output | 8 | Context FIFO fill level |
| glb_a | input | 8 | Global data from channel 0 |
| glb_b | input | 8 | Global data from channel 1 |
| glb_out | output | 8 | Global data routed by context channel |

## Verification
The assertions assume that reset is applied at start-up and that the acknowledge and update inputs are synchronous to the clock. They also assume the fill and source inputs are sampled only at clock edges, so a capture reflects the state one edge earlier. The stimulus changes every input on the falling clock edge. It waits at least one rising edge between a source or register change and the capture that should see it. It drops acknowledge for at least one cycle before raising it again, except in the one case that holds acknowledge high on purpose to show that no recapture happens.

// File: rtl/bid_irq_arbiter.sv
module bid_irq_arbiter #(
  parameter int NSRC   = 18,
  parameter int PER_CH = 9,
  parameter int DW     = 8,
  parameter int FILLW  = 8,
  parameter int AW     = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [NSRC-1:0]          src_act,
  input  logic [NSRC-1:0]          src_mask,
  input  logic [FILLW-1:0]         rx_fill_a,
  input  logic [FILLW-1:0]         rx_fill_b,
  input  logic [FILLW-1:0]         tx_fill_a,
  input  logic [FILLW-1:0]         tx_fill_b,
  input  logic                     iack,
  input  logic                     upd_cmd,
  output logic                     irq_n,
  output logic [DW-1:0]            vector,
  output logic                     ctx_valid,
  output logic                     ctx_chan,
  output logic [2:0]               ctx_type,
  output logic [$clog2(NSRC)-1:0]  ctx_src,
  output logic [FILLW-1:0]         ctx_fill,
  input  logic [DW-1:0]            glb_a,
  input  logic [DW-1:0]            glb_b,
  output logic [DW-1:0]            glb_out
);
  localparam int SRCW  = $clog2(NSRC);
  localparam int A_THR = NSRC;
  localparam int A_VEC = NSRC + 1;
  localparam int A_CTL = NSRC + 2;

  logic [DW-1:0] bid [NSRC];
  logic [DW-1:0] thr, vreg;
  logic [1:0]    ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) bid[i] <= '0;
      thr  <= '0;
      vreg <= '0;
      ctl  <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NSRC; i++)
        if (wr_addr == AW'(i)) bid[i] <= wr_data;
      if (wr_addr == AW'(A_THR)) thr  <= wr_data;
      if (wr_addr == AW'(A_VEC)) vreg <= wr_data;
      if (wr_addr == AW'(A_CTL)) ctl  <= wr_data[1:0];
    end
  end

  logic [DW-1:0]    best;
  logic [SRCW-1:0]  win;

  always_comb begin
    best = '0;
    win  = '0;
    for (int i = 0; i < NSRC; i++)
      if (src_act[i] && !src_mask[i] && bid[i] > best) begin
        best = bid[i];
        win  = SRCW'(i);
      end
  end

  logic             win_hit, win_chan;
  logic [SRCW-1:0]  win_loc;
  logic [2:0]       win_type;
  logic [FILLW-1:0] win_fill;

  assign win_hit  = best > thr;
  assign win_chan = win >= SRCW'(PER_CH);
  assign win_loc  = win_chan ? win - SRCW'(PER_CH) : win;
  assign win_type = (win_loc > SRCW'(6)) ? 3'd7 : win_loc[2:0];

  always_comb begin
    case (win_type)
      3'd0:    win_fill = win_chan ? rx_fill_b : rx_fill_a;
      3'd1:    win_fill = win_chan ? tx_fill_b : tx_fill_a;
      default: win_fill = '0;
    endcase
  end

  logic             arb_hit, arb_chan;
  logic [2:0]       arb_type;
  logic [SRCW-1:0]  arb_src;
  logic [FILLW-1:0] arb_fill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arb_hit  <= 1'b0;
      arb_chan <= 1'b0;
      arb_type <= '0;
      arb_src  <= '0;
      arb_fill <= '0;
    end else begin
      arb_hit  <= win_hit;
      arb_chan <= win_hit & win_chan;
      arb_type <= win_hit ? win_type : 3'd0;
      arb_src  <= win_hit ? win : '0;
      arb_fill <= win_hit ? win_fill : '0;
    end
  end

  assign irq_n = ~arb_hit;

  logic iack_q, take;
  assign take = (iack && !iack_q) || upd_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iack_q    <= 1'b0;
      ctx_valid <= 1'b0;
      ctx_chan  <= 1'b0;
      ctx_type  <= '0;
      ctx_src   <= '0;
      ctx_fill  <= '0;
    end else begin
      iack_q <= iack;
      if (take) begin
        ctx_valid <= arb_hit;
        ctx_chan  <= arb_chan;
        ctx_type  <= arb_type;
        ctx_src   <= arb_src;
        ctx_fill  <= arb_fill;
      end
    end
  end

  assign vector  = {vreg[DW-1:4], ctl[1] ? ctx_chan : vreg[3], ctl[0] ? ctx_type : vreg[2:0]};
  assign glb_out = ctx_chan ? glb_b : glb_a;

  a_r6_ctx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable({ctx_valid, ctx_chan, ctx_type, ctx_src, ctx_fill}));

  a_r12_no_req_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_n) |=> (!ctx_valid && ctx_src == '0 && ctx_fill == '0));

  a_r5_req_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !irq_n) |=> ctx_valid);

  a_r7_chan_of_src: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_valid |-> (ctx_chan == (ctx_src >= SRCW'(PER_CH))));

  a_r8_fill_only_fifo: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_type > 3'd1) |-> (ctx_fill == '0));
endmodule

// File: tb/bid_irq_arbiter_tb.sv
`timescale 1ns/1ps
module bid_irq_arbiter_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, wr_en, iack, upd_cmd, irq_n;
  logic [4:0]  wr_addr;
  logic [7:0]  wr_data, vector, glb_a, glb_b, glb_out;
  logic [17:0] src_act, src_mask;
  logic [7:0]  rx_fill_a, rx_fill_b, tx_fill_a, tx_fill_b, ctx_fill;
  logic        ctx_valid, ctx_chan;
  logic [2:0]  ctx_type;
  logic [4:0]  ctx_src;

  bid_irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_act(src_act), .src_mask(src_mask),
    .rx_fill_a(rx_fill_a), .rx_fill_b(rx_fill_b), .tx_fill_a(tx_fill_a), .tx_fill_b(tx_fill_b),
    .iack(iack), .upd_cmd(upd_cmd), .irq_n(irq_n), .vector(vector),
    .ctx_valid(ctx_valid), .ctx_chan(ctx_chan), .ctx_type(ctx_type), .ctx_src(ctx_src),
    .ctx_fill(ctx_fill), .glb_a(glb_a), .glb_b(glb_b), .glb_out(glb_out)
  );

  typedef struct packed {
    logic       valid;
    logic       chan;
    logic [2:0] typ;
    logic [4:0] src;
    logic [7:0] fill;
    logic [7:0] vec;
  } item_t;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t q[$];
  event mon_ev;

  logic [7:0] m_bid [18];
  logic [7:0] m_thr, m_vec;
  logic [1:0] m_ctl;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic item_t model();
    item_t it;
    logic [7:0] best;
    int w, loc;
    best = 0; w = 0;
    for (int i = 0; i < 18; i++)
      if (src_act[i] && !src_mask[i] && m_bid[i] > best) begin best = m_bid[i]; w = i; end
    it = '0;
    if (best > m_thr) begin
      it.valid = 1'b1;
      it.chan  = (w >= 9);
      loc      = it.chan ? w - 9 : w;
      it.typ   = (loc > 6) ? 3'd7 : 3'(loc);
      it.src   = 5'(w);
      it.fill  = (it.typ == 0) ? (it.chan ? rx_fill_b : rx_fill_a) :
                 (it.typ == 1) ? (it.chan ? tx_fill_b : tx_fill_a) : 8'd0;
    end
    it.vec = {m_vec[7:4], m_ctl[1] ? it.chan : m_vec[3], m_ctl[0] ? it.typ : m_vec[2:0]};
    return it;
  endfunction

  function automatic item_t observed();
    return {ctx_valid, ctx_chan, ctx_type, ctx_src, ctx_fill, vector};
  endfunction

  string cur_req = "R1";

  initial begin
    item_t e;
    forever begin
      @(mon_ev);
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL %s: actual capture with no expected item, expected queued item", cur_req);
      end else begin
        e = q.pop_front();
        chk(cur_req, 32'(observed()), 32'(e));
      end
    end
  end

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    if (a < 18) m_bid[a] = d;
    else if (a == 18) m_thr = d;
    else if (a == 19) m_vec = d;
    else if (a == 20) m_ctl = d[1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic cap(string req, bit use_upd);
    settle();
    cur_req = req;
    q.push_back(model());
    if (use_upd) upd_cmd = 1'b1; else iack = 1'b1;
    @(negedge clk);
    iack = 1'b0; upd_cmd = 1'b0;
    ->mon_ev;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    item_t held;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; iack = 1'b0; upd_cmd = 1'b0;
    src_act = '0; src_mask = '0; rx_fill_a = 8'h44; rx_fill_b = 8'h33;
    tx_fill_a = 8'h21; tx_fill_b = 8'h55; glb_a = 8'h11; glb_b = 8'h22;
    for (int i = 0; i < 18; i++) m_bid[i] = 8'h00;
    m_thr = 0; m_vec = 0; m_ctl = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", 32'(irq_n), 32'd1);
    chk("R1", 32'(observed()), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 32'(irq_n), 32'd1);

    wr(18, 8'h10); wr(19, 8'hA5);
    wr(3, 8'h40); wr(12, 8'h80); wr(5, 8'h80); wr(9, 8'hF0);
    wr(1, 8'h90); wr(17, 8'hC0); wr(8, 8'hC0);

    settle();
    chk("R4", 32'(irq_n), 32'd1);
    cap("R12", 1'b0);

    src_act = 18'(1 << 3) | 18'(1 << 12);
    settle();
    chk("R5", 32'(irq_n), 32'd0);
    cap("R2", 1'b0);
    chk("R10", 32'(glb_out), 32'h22);

    src_act[5] = 1'b1;
    cap("R3", 1'b0);
    chk("R10", 32'(glb_out), 32'h11);

    src_mask[5] = 1'b1;
    cap("R4", 1'b0);
    wr(12, 8'h00);
    cap("R4", 1'b0);

    wr(18, 8'h40);
    settle();
    chk("R5", 32'(irq_n), 32'd1);
    cap("R5", 1'b0);
    wr(18, 8'h3F);
    settle();
    chk("R5", 32'(irq_n), 32'd0);

    src_act = 18'(1 << 9);
    cap("R8", 1'b0);
    src_act = 18'(1 << 1);
    cap("R8", 1'b0);
    src_act = 18'(1 << 8) | 18'(1 << 17);
    cap("R7", 1'b0);
    src_act = 18'(1 << 17);
    cap("R7", 1'b0);
    src_act = 18'(1 << 6);
    wr(6, 8'h77);
    cap("R7", 1'b0);

    src_act = 18'(1 << 17);
    wr(20, 8'h01); cap("R9", 1'b0);
    wr(20, 8'h02); cap("R9", 1'b0);
    wr(20, 8'h03); cap("R9", 1'b0);

    src_act = 18'(1 << 9);
    cap("R6", 1'b1);
    held = observed();
    src_act = '0;
    repeat (4) @(negedge clk);
    chk("R6", 32'(observed()), 32'(held));
    cap("R6", 1'b1);

    src_act = 18'(1 << 1);
    settle();
    held = model();
    iack = 1'b1;
    @(negedge clk);
    chk("R6", 32'(observed()), 32'(held));
    src_act = 18'(1 << 9);
    repeat (4) @(negedge clk);
    chk("R6", 32'(observed()), 32'(held));
    iack = 1'b0;

    wr(25, 8'hFF); wr(21, 8'h00); wr(31, 8'h5A);
    chk("R11", 32'(vector), 32'(held.vec));
    cap("R11", 1'b0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule